// File: doc/BRIEF.md
# Load/Store Instruction Sequencer

This block is the control unit of a very small 8-bit processor. It executes a handful of accumulator load and store instructions, with exactly one memory access in every clock cycle. It holds a 16-bit program counter and two accumulators, A and B. A four-state machine walks each instruction through its opcode fetch, zero to two operand fetches, and at most one data read or write.

The memory bus is synchronous and has no handshake. In every cycle the block drives an address and a write strobe. For a read, the memory returns the addressed byte within the same cycle. For a write, the block drives the new byte in that cycle. The memory can never stall the block and there is no back-pressure, so the cycle count of each instruction is fixed by its opcode alone.

A 16-bit address is assembled from the instruction stream, most significant byte first. A direct address takes a single byte, and its upper byte is zero. Two single-cycle pulses mark the last cycle of every instruction and any opcode that is not recognised, so cycles per instruction can be counted from outside.

Top module: `ldst_seq`

## Requirements
- R1: While synchronous reset `rst` is high, at the next clock edge the program counter loads START_ADDR (default 0xE000), both accumulators clear to zero, and the machine returns to opcode fetch.
- R2: Every cycle performs exactly one memory access. The first cycle of each instruction is a read (`mem_we` = 0) at the address in the program counter. Every cycle that is not the data cycle advances the program counter by one.
- R3: Opcode 0x86 loads A with the byte that follows the opcode. It takes 2 cycles.
- R4: Opcode 0xC6 loads B with the byte that follows the opcode. It takes 2 cycles and leaves A unchanged.
- R5: Opcode 0xB6 reads two address bytes, upper byte first. It then reads the byte at that 16-bit address into A, for 4 cycles in total.
- R6: Opcode 0xB7 reads two address bytes, upper byte first. In its fourth and last cycle it writes A to that address. This is the only write cycle of the instruction.
- R7: Opcode 0x97 reads one address byte as the lower byte, with the upper byte zero. In its third and last cycle it writes A there.
- R8: Opcode 0x96 reads one address byte as the lower byte, with the upper byte zero. It loads A from that address in 3 cycles.
- R9: After each instruction, the program counter equals the opcode address plus the instruction length: 1 for an unknown opcode, 2 for immediate, 2 for direct and 3 for extended.
- R10: Any other opcode takes 1 cycle, raises `illegal_op` during that cycle, advances the program counter by one, and leaves A and B unchanged.
- R11: `instr_done` is high only in the last cycle of each instruction, once per instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 8 | Byte returned by memory in the same cycle |
| mem_addr | output | 16 | Address of this cycle's access |
| mem_wdata | output | 8 | Byte to write (accumulator A) |
| mem_we | output | 1 | 1 = write this cycle, 0 = read |
| acc_a | output | 8 | Accumulator A |
| acc_b | output | 8 | Accumulator B |
| pc_out | output | 16 | Program counter |
| instr_done | output | 1 | High in the last cycle of an instruction |
| illegal_op | output | 1 | High in the cycle an unknown opcode is fetched |

## Verification
The assertions take for granted that `mem_rdata` carries a defined byte in every cycle, answered combinationally from the address of that same cycle. They also assume that reset is held across at least one clock edge before the first instruction. The bench memory is a pure function of the address. Program bytes sit in a small window at the start address, and every other address returns an arithmetic pattern that differs when the two address bytes are swapped. The bench keeps all data addresses away from the program window, so loads never read program bytes and stores never overwrite them.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam logic [7:0] OPC_LDA_IMM = 8'h86;
  localparam logic [7:0] OPC_LDB_IMM = 8'hC6;
  localparam logic [7:0] OPC_LDA_DIR = 8'h96;
  localparam logic [7:0] OPC_STA_DIR = 8'h97;
  localparam logic [7:0] OPC_LDA_EXT = 8'hB6;
  localparam logic [7:0] OPC_STA_EXT = 8'hB7;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_OPND1,
    ST_OPND2,
    ST_DATA
  } seq_state_t;

  typedef enum logic [1:0] {
    AM_IMM,
    AM_DIR,
    AM_EXT
  } addr_mode_t;

  typedef struct packed {
    logic       known;
    addr_mode_t mode;
    logic       store;
    logic       to_b;
  } op_info_t;

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic [7:0] opcode,
  output op_info_t   info
);

  always_comb begin
    info = '{known: 1'b1, mode: AM_IMM, store: 1'b0, to_b: 1'b0};
    unique case (opcode)
      OPC_LDA_IMM: info.mode = AM_IMM;
      OPC_LDB_IMM: begin
        info.mode = AM_IMM;
        info.to_b = 1'b1;
      end
      OPC_LDA_DIR: info.mode = AM_DIR;
      OPC_STA_DIR: begin
        info.mode  = AM_DIR;
        info.store = 1'b1;
      end
      OPC_LDA_EXT: info.mode = AM_EXT;
      OPC_STA_EXT: begin
        info.mode  = AM_EXT;
        info.store = 1'b1;
      end
      default: info.known = 1'b0;
    endcase
  end

endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  op_info_t fetched,
  output logic     pc_inc,
  output logic     ld_a,
  output logic     ld_b,
  output logic     lat_hi,
  output logic     clr_hi,
  output logic     lat_lo,
  output logic     use_eff,
  output logic     we,
  output logic     done,
  output logic     illegal
);

  seq_state_t state_q, state_d;
  op_info_t   op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FETCH && fetched.known) op_q <= fetched;
    end
  end

  always_comb begin
    state_d = state_q;
    pc_inc  = 1'b1;
    ld_a    = 1'b0;
    ld_b    = 1'b0;
    lat_hi  = 1'b0;
    clr_hi  = 1'b0;
    lat_lo  = 1'b0;
    use_eff = 1'b0;
    we      = 1'b0;
    done    = 1'b0;
    illegal = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        if (fetched.known) begin
          state_d = ST_OPND1;
        end else begin
          done    = 1'b1;
          illegal = 1'b1;
        end
      end
      ST_OPND1: begin
        unique case (op_q.mode)
          AM_DIR: begin
            clr_hi  = 1'b1;
            lat_lo  = 1'b1;
            state_d = ST_DATA;
          end
          AM_EXT: begin
            lat_hi  = 1'b1;
            state_d = ST_OPND2;
          end
          default: begin
            ld_a    = ~op_q.to_b;
            ld_b    = op_q.to_b;
            done    = 1'b1;
            state_d = ST_FETCH;
          end
        endcase
      end
      ST_OPND2: begin
        lat_lo  = 1'b1;
        state_d = ST_DATA;
      end
      default: begin
        pc_inc  = 1'b0;
        use_eff = 1'b1;
        we      = op_q.store;
        ld_a    = ~op_q.store;
        done    = 1'b1;
        state_d = ST_FETCH;
      end
    endcase
  end

  // R10
  illegal_in_done_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> done && !we);

  // R6
  write_last_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> done && use_eff);

  // R11
  done_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !use_eff && !we);

endmodule

// File: rtl/ldst_dpath.sv
module ldst_dpath #(
  parameter int unsigned DW = 8,
  parameter logic [2*DW-1:0] START_ADDR = 16'hE000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   rdata,
  input  logic            pc_inc,
  input  logic            ld_a,
  input  logic            ld_b,
  input  logic            lat_hi,
  input  logic            clr_hi,
  input  logic            lat_lo,
  input  logic            use_eff,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW-1:0]   acc_a,
  output logic [DW-1:0]   acc_b,
  output logic [2*DW-1:0] pc_out
);

  localparam int unsigned AW = 2 * DW;
  localparam logic [AW-1:0] PC_STEP = AW'(1);

  logic [AW-1:0] pc_q;
  logic [DW-1:0] a_q, b_q, hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= START_ADDR;
      a_q  <= '0;
      b_q  <= '0;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (pc_inc) pc_q <= pc_q + PC_STEP;
      if (ld_a)   a_q  <= rdata;
      if (ld_b)   b_q  <= rdata;
      if (clr_hi)      hi_q <= '0;
      else if (lat_hi) hi_q <= rdata;
      if (lat_lo) lo_q <= rdata;
    end
  end

  assign mem_addr  = use_eff ? {hi_q, lo_q} : pc_q;
  assign mem_wdata = a_q;
  assign acc_a     = a_q;
  assign acc_b     = b_q;
  assign pc_out    = pc_q;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !use_eff |=> pc_q == $past(pc_q) + PC_STEP);

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    use_eff |=> $stable(pc_q));

endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
  import ldst_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter logic [2*DW-1:0] START_ADDR = 16'hE000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic [DW-1:0]   acc_a,
  output logic [DW-1:0]   acc_b,
  output logic [2*DW-1:0] pc_out,
  output logic            instr_done,
  output logic            illegal_op
);

  op_info_t fetched;
  logic pc_inc, ld_a, ld_b, lat_hi, clr_hi, lat_lo, use_eff;

  ldst_decode u_decode (
    .opcode (mem_rdata[7:0]),
    .info   (fetched)
  );

  ldst_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .fetched (fetched),
    .pc_inc  (pc_inc),
    .ld_a    (ld_a),
    .ld_b    (ld_b),
    .lat_hi  (lat_hi),
    .clr_hi  (clr_hi),
    .lat_lo  (lat_lo),
    .use_eff (use_eff),
    .we      (mem_we),
    .done    (instr_done),
    .illegal (illegal_op)
  );

  ldst_dpath #(.DW(DW), .START_ADDR(START_ADDR)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .rdata     (mem_rdata),
    .pc_inc    (pc_inc),
    .ld_a      (ld_a),
    .ld_b      (ld_b),
    .lat_hi    (lat_hi),
    .clr_hi    (clr_hi),
    .lat_lo    (lat_lo),
    .use_eff   (use_eff),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .acc_a     (acc_a),
    .acc_b     (acc_b),
    .pc_out    (pc_out)
  );

  // R2
  fetch_at_pc_chk: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> !mem_we && mem_addr == pc_out);

  // R10
  illegal_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_op |=> $stable(acc_a) && $stable(acc_b));

endmodule

// File: tb/test_ldst_seq.sv
module test_ldst_seq;

  localparam logic [15:0] BASE = 16'hE000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  acc_a, acc_b;
  logic [15:0] pc_out;
  logic        instr_done, illegal_op;

  int checks = 0;
  int errors = 0;

  logic [7:0] prog [0:63];

  int          r_cyc, r_wcnt;
  logic [15:0] r_first_addr, r_last_addr, r_waddr;
  logic        r_first_we, r_ill;
  logic [7:0]  r_wdata;

  always #10 clk = ~clk;

  ldst_seq i_ldst_seq (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .acc_a(acc_a), .acc_b(acc_b),
    .pc_out(pc_out), .instr_done(instr_done), .illegal_op(illegal_op)
  );

  function automatic logic [7:0] pattern(input logic [15:0] ad);
    return ad[15:8] ^ {ad[6:0], ad[7]} ^ 8'h5A;
  endfunction

  always_comb begin
    logic [15:0] off;
    off = mem_addr - BASE;
    if (off < 16'd64) mem_rdata = prog[off[5:0]];
    else              mem_rdata = pattern(mem_addr);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = 8'h01;
  endtask

  task automatic restart();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_instr();
    r_cyc = 0; r_wcnt = 0; r_ill = 1'b0;
    forever begin
      #1;
      if (r_cyc == 0) begin
        r_first_addr = mem_addr;
        r_first_we   = mem_we;
      end
      r_cyc++;
      r_last_addr = mem_addr;
      if (mem_we) begin
        r_wcnt++;
        r_waddr = mem_addr;
        r_wdata = mem_wdata;
      end
      if (illegal_op) r_ill = 1'b1;
      if (instr_done || r_cyc > 8) begin
        @(negedge clk);
        #1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic chk_fetch(input logic [15:0] exp_pc, input string tag);
    chk(r_first_addr == exp_pc && !r_first_we, "R2", tag, r_first_addr, exp_pc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_prog();
    // R1: reset state seen while reset is held after a clock edge
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(pc_out == BASE, "R1", "reset pc", pc_out, BASE);
    chk(acc_a == 0 && acc_b == 0, "R1", "reset accumulators", {acc_a, acc_b}, 0);
    chk(!mem_we && mem_addr == BASE, "R1", "reset fetch address", mem_addr, BASE);

    // R3: immediate load into A, sweep of values
    for (int v = 0; v < 256; v += 17) begin
      clear_prog();
      prog[0] = 8'h86; prog[1] = 8'(v);
      restart();
      run_instr();
      chk_fetch(BASE, "imm A fetch");
      chk(r_cyc == 2 && !r_ill && r_wcnt == 0, "R3", "imm A cycles", r_cyc, 2);
      chk(acc_a == 8'(v), "R3", "imm A value", acc_a, v);
      chk(pc_out == BASE + 16'd2, "R9", "imm A pc", pc_out, BASE + 16'd2);
    end

    // R4: immediate load into B, A must keep its earlier value
    for (int v = 3; v < 256; v += 29) begin
      clear_prog();
      prog[0] = 8'h86; prog[1] = 8'h11; prog[2] = 8'hC6; prog[3] = 8'(v);
      restart();
      run_instr();
      run_instr();
      chk_fetch(BASE + 16'd2, "imm B fetch");
      chk(r_cyc == 2 && !r_ill, "R4", "imm B cycles", r_cyc, 2);
      chk(acc_b == 8'(v) && acc_a == 8'h11, "R4", "imm B value / A kept",
          {acc_a, acc_b}, {8'h11, 8'(v)});
      chk(pc_out == BASE + 16'd4, "R9", "imm B pc", pc_out, BASE + 16'd4);
    end

    // R5, R6: extended load and store over a grid of addresses
    for (int h = 0; h < 6; h++) begin
      for (int l = 0; l < 5; l++) begin
        logic [7:0]  hb, lb, v;
        logic [15:0] ea;
        hb = (h == 0) ? 8'h00 : (h == 1) ? 8'h12 : (h == 2) ? 8'h34 :
             (h == 3) ? 8'hFF : (h == 4) ? 8'hA5 : 8'h7F;
        lb = (l == 0) ? 8'h00 : (l == 1) ? 8'h34 : (l == 2) ? 8'h12 :
             (l == 3) ? 8'hFF : 8'h81;
        ea = {hb, lb};
        clear_prog();
        prog[0] = 8'hB6; prog[1] = hb; prog[2] = lb;
        restart();
        run_instr();
        chk_fetch(BASE, "ext load fetch");
        chk(r_cyc == 4 && r_wcnt == 0 && !r_ill, "R5", "ext load cycles", r_cyc, 4);
        chk(r_last_addr == ea, "R5", "ext load address", r_last_addr, ea);
        chk(acc_a == pattern(ea), "R5", "ext load value", acc_a, pattern(ea));
        chk(pc_out == BASE + 16'd3, "R9", "ext load pc", pc_out, BASE + 16'd3);

        v = hb ^ lb ^ 8'h3C;
        clear_prog();
        prog[0] = 8'h86; prog[1] = v; prog[2] = 8'hB7; prog[3] = hb; prog[4] = lb;
        restart();
        run_instr();
        run_instr();
        chk_fetch(BASE + 16'd2, "ext store fetch");
        chk(r_cyc == 4 && r_wcnt == 1, "R6", "ext store cycles/writes", r_cyc, 4);
        chk(r_waddr == ea && r_wdata == v, "R6", "ext store address/data",
            {r_waddr, r_wdata}, {ea, v});
        chk(pc_out == BASE + 16'd5, "R9", "ext store pc", pc_out, BASE + 16'd5);
      end
    end

    // R7, R8: direct store and load, upper address byte zero
    for (int l = 0; l < 256; l += 51) begin
      logic [7:0] v;
      v = 8'(l) ^ 8'hC3;
      clear_prog();
      prog[0] = 8'h86; prog[1] = v; prog[2] = 8'h97; prog[3] = 8'(l);
      restart();
      run_instr();
      run_instr();
      chk(r_cyc == 3 && r_wcnt == 1, "R7", "dir store cycles/writes", r_cyc, 3);
      chk(r_waddr == {8'h00, 8'(l)} && r_wdata == v, "R7", "dir store address/data",
          {r_waddr, r_wdata}, {8'h00, 8'(l), v});
      chk(pc_out == BASE + 16'd4, "R9", "dir store pc", pc_out, BASE + 16'd4);

      clear_prog();
      prog[0] = 8'h96; prog[1] = 8'(l);
      restart();
      run_instr();
      chk(r_cyc == 3 && r_wcnt == 0 && !r_ill, "R8", "dir load cycles", r_cyc, 3);
      chk(acc_a == pattern({8'h00, 8'(l)}), "R8", "dir load value", acc_a,
          pattern({8'h00, 8'(l)}));
      chk(pc_out == BASE + 16'd2, "R9", "dir load pc", pc_out, BASE + 16'd2);
    end

    // R10: every unknown opcode, with A and B preloaded
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h86 || op == 8'hC6 || op == 8'h96 || op == 8'h97 ||
          op == 8'hB6 || op == 8'hB7) continue;
      clear_prog();
      prog[0] = 8'h86; prog[1] = 8'h3C; prog[2] = 8'hC6; prog[3] = 8'hA5;
      prog[4] = 8'(op);
      restart();
      run_instr();
      run_instr();
      run_instr();
      chk(r_cyc == 1 && r_ill && r_wcnt == 0, "R10", "unknown opcode cycle/flag",
          r_cyc, 1);
      chk(pc_out == BASE + 16'd5 && acc_a == 8'h3C && acc_b == 8'hA5, "R10",
          "unknown opcode pc/accumulators", {pc_out, acc_a, acc_b},
          {BASE + 16'd5, 8'h3C, 8'hA5});
    end

    // R11: back-to-back mix, one done per instruction and exact lengths
    clear_prog();
    prog[0] = 8'hC6; prog[1] = 8'h5A;
    prog[2] = 8'h01;
    prog[3] = 8'hB6; prog[4] = 8'h12; prog[5] = 8'h34;
    prog[6] = 8'h97; prog[7] = 8'h40;
    prog[8] = 8'h86; prog[9] = 8'hFF;
    restart();
    run_instr();
    chk(r_cyc == 2 && pc_out == BASE + 16'd2, "R11", "mix step 1", r_cyc, 2);
    run_instr();
    chk(r_cyc == 1 && r_ill && pc_out == BASE + 16'd3, "R11", "mix step 2", r_cyc, 1);
    run_instr();
    chk_fetch(BASE + 16'd3, "mix step 3 fetch");
    chk(r_cyc == 4 && acc_a == pattern(16'h1234), "R11", "mix step 3", r_cyc, 4);
    run_instr();
    chk(r_cyc == 3 && r_waddr == 16'h0040 && r_wdata == pattern(16'h1234), "R11",
        "mix step 4", r_waddr, 16'h0040);
    run_instr();
    chk(r_cyc == 2 && acc_a == 8'hFF && acc_b == 8'h5A &&
        pc_out == BASE + 16'd10, "R11", "mix step 5", pc_out, BASE + 16'd10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule